// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Unit

This block holds one 32-bit program counter for each hardware thread and issues word-aligned fetch requests to instruction memory for the thread that the surrounding pipeline selects through `thread_sel`. The request carries the upper 30 bits of the selected PC as a word address. The two low PC bits leave the block separately as a byte offset, for use by the byte-wide instruction window downstream. When memory accepts a request through the valid/ready handshake, the selected thread's PC steps forward by four.

Branches follow a static not-taken policy, so fetch keeps running sequentially. When the execute stage resolves a branch, it returns a target address tagged with a thread number. Only that thread's PC is reloaded, whether or not that thread is currently selected. One cycle later the block pulses a flush to the instruction window, together with the thread number, so that the window discards the bytes it holds for that thread.

Top module: `mt_fetch_unit`

## Requirements
- R1: While `rst_n` is low, `req_valid` and `flush` are 0. After reset every thread's PC equals the parameter `RESET_PC` (default 0).
- R2: Out of reset, `req_valid` is 1 in every cycle. `req_addr` equals bits 31:2 of the selected thread's PC, `req_off` equals bits 1:0 of that PC, and `req_tid` equals `thread_sel`. All three are combinational on `thread_sel`.
- R3: A cycle with `req_valid` and `req_ready` both high adds 4 to the selected thread's PC at the next clock edge. Bits 1:0 are unchanged.
- R4: A cycle with `req_ready` low and no redirect leaves every PC unchanged.
- R5: A cycle with `redir_valid` high loads `redir_target` into the PC of thread `redir_tid` at the next clock edge. The PCs of all other threads are not affected by the redirect.
- R6: A redirect aimed at a thread other than the selected one still reloads that thread. An accepted request in the same cycle still advances the selected thread.
- R7: When a redirect and an accepted request target the same thread in the same cycle, the redirect target wins and no step of 4 is applied.
- R8: `flush` is 1 in exactly the cycle after a cycle with `redir_valid` high, and `flush_tid` then holds that cycle's `redir_tid`. Otherwise `flush` is 0.
- R9: PC arithmetic wraps modulo 2^32. For example, 0xFFFFFFFE plus one accepted step gives 0x00000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_sel | input | TID_W | Thread to fetch for in this cycle |
| req_ready | input | 1 | Memory accepts the request |
| redir_valid | input | 1 | Resolved branch target present |
| redir_tid | input | TID_W | Thread the target belongs to |
| redir_target | input | 32 | Branch target address |
| req_valid | output | 1 | Fetch request present |
| req_addr | output | 30 | Word address, selected PC bits 31:2 |
| req_off | output | 2 | Byte offset, selected PC bits 1:0 |
| req_tid | output | TID_W | Thread of the request |
| flush | output | 1 | Clear the instruction window |
| flush_tid | output | TID_W | Thread whose window content is cleared |

## Verification
Sequential fetch runs with memory always ready. This shows that the step is 4 and that it lands only on the selected thread. Stalled cycles with `req_ready` low separate "advance on acceptance" from "advance every cycle". Redirects are tried three ways: to the selected thread while stalled, to the other thread while the selected one is accepted, and to the selected thread while it is accepted. Together these separate per-thread reload from global reload, and show redirect priority over the step. A target with nonzero low bits near the top of the address space shows that the offset bits are kept and that the address wraps.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int PC_W   = 32;
  localparam int WORD_W = PC_W - 2;

  // next sequential fetch PC: one 4-byte word further, offset bits kept
  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  // memory word address carried by a PC
  function automatic logic [WORD_W-1:0] pc_word(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:2];
  endfunction

  // byte offset kept for use inside the pipeline
  function automatic logic [1:0] pc_byte(input logic [PC_W-1:0] pc);
    return pc[1:0];
  endfunction
endpackage

// File: rtl/mtf_pc_slot.sv
module mtf_pc_slot
  import mtf_pkg::*;
#(
  parameter int          TID_W    = 1,
  parameter int          SLOT_ID  = 0,
  parameter logic [31:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] sel_tid,
  input  logic             fire,
  input  logic             redir_valid,
  input  logic [TID_W-1:0] redir_tid,
  input  logic [PC_W-1:0]  redir_target,
  output logic [PC_W-1:0]  pc
);
  logic hit_redir;
  logic hit_step;

  assign hit_redir = redir_valid && (redir_tid == TID_W'(SLOT_ID));
  assign hit_step  = fire && (sel_tid == TID_W'(SLOT_ID));

  always_ff @(posedge clk) begin
    if (!rst_n)         pc <= RESET_PC;
    else if (hit_redir) pc <= redir_target;   // redirect beats sequential step
    else if (hit_step)  pc <= pc_step(pc);
  end
endmodule

// File: rtl/mtf_pc_select.sv
module mtf_pc_select
  import mtf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1
) (
  input  logic [NUM_THREADS-1:0][PC_W-1:0] pcs,
  input  logic [TID_W-1:0]                 sel,
  output logic [PC_W-1:0]                  pc_out
);
  always_comb begin
    pc_out = '0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (sel == TID_W'(i)) pc_out = pcs[i];
  end
endmodule

// File: rtl/mtf_flush_gen.sv
module mtf_flush_gen #(
  parameter int TID_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redir_valid,
  input  logic [TID_W-1:0] redir_tid,
  output logic             flush,
  output logic [TID_W-1:0] flush_tid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush     <= 1'b0;
      flush_tid <= '0;
    end else begin
      flush     <= redir_valid;
      flush_tid <= redir_valid ? redir_tid : flush_tid;
    end
  end
endmodule

// File: rtl/mt_fetch_unit.sv
module mt_fetch_unit
  import mtf_pkg::*;
#(
  parameter int          NUM_THREADS = 2,
  parameter logic [31:0] RESET_PC    = '0,
  localparam int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  thread_sel,
  input  logic              req_ready,
  input  logic              redir_valid,
  input  logic [TID_W-1:0]  redir_tid,
  input  logic [31:0]       redir_target,
  output logic              req_valid,
  output logic [29:0]       req_addr,
  output logic [1:0]        req_off,
  output logic [TID_W-1:0]  req_tid,
  output logic              flush,
  output logic [TID_W-1:0]  flush_tid
);
  logic [NUM_THREADS-1:0][PC_W-1:0] pcs;
  logic [PC_W-1:0]                  sel_pc;
  logic                             fire;

  assign req_valid = rst_n;
  assign fire      = req_valid && req_ready;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
    mtf_pc_slot #(
      .TID_W(TID_W), .SLOT_ID(t), .RESET_PC(RESET_PC)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .sel_tid(thread_sel), .fire(fire),
      .redir_valid(redir_valid), .redir_tid(redir_tid),
      .redir_target(redir_target), .pc(pcs[t])
    );
  end

  mtf_pc_select #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_sel (
    .pcs(pcs), .sel(thread_sel), .pc_out(sel_pc)
  );

  assign req_addr = pc_word(sel_pc);
  assign req_off  = pc_byte(sel_pc);
  assign req_tid  = thread_sel;

  mtf_flush_gen #(.TID_W(TID_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
    .redir_tid(redir_tid), .flush(flush), .flush_tid(flush_tid)
  );
endmodule

// File: rtl/mt_fetch_unit_chk.sv
module mt_fetch_unit_chk #(
  parameter int TID_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TID_W-1:0] thread_sel,
  input logic             req_ready,
  input logic             redir_valid,
  input logic [TID_W-1:0] redir_tid,
  input logic [31:0]      redir_target,
  input logic             req_valid,
  input logic [29:0]      req_addr,
  input logic [1:0]       req_off,
  input logic             flush,
  input logic [TID_W-1:0] flush_tid
);
  logic        own_redir;
  logic        fired;
  logic [31:0] seen_pc;

  assign own_redir = redir_valid && (redir_tid == thread_sel);
  assign fired     = req_valid && req_ready;
  assign seen_pc   = {req_addr, req_off};

  always_comb if (!rst_n) AST_RESET_QUIET: assert (!req_valid); // R1

  AST_REQ_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> req_valid); // R2

  AST_STEP_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !own_redir) |=> ($stable(thread_sel) -> seen_pc == $past(seen_pc) + 32'd4)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !redir_valid) |=> ($stable(thread_sel) -> $stable(seen_pc))); // R4

  AST_REDIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    own_redir |=> ($stable(thread_sel) -> seen_pc == $past(redir_target))); // R7

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (flush && flush_tid == $past(redir_tid))); // R8

  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |=> !flush); // R8
endmodule

bind mt_fetch_unit mt_fetch_unit_chk #(.TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .thread_sel(thread_sel), .req_ready(req_ready),
  .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_target(redir_target),
  .req_valid(req_valid), .req_addr(req_addr), .req_off(req_off),
  .flush(flush), .flush_tid(flush_tid)
);

// File: tb/mt_fetch_unit_bench.sv
module mt_fetch_unit_bench;
  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        thread_sel = 1'b0;
  logic        req_ready = 1'b0;
  logic        redir_valid = 1'b0;
  logic        redir_tid = 1'b0;
  logic [31:0] redir_target = '0;
  logic        req_valid;
  logic [29:0] req_addr;
  logic [1:0]  req_off;
  logic        req_tid;
  logic        flush;
  logic        flush_tid;

  int total = 0;
  int bad   = 0;
  logic [31:0] model [NT];

  always #4 clk = ~clk;   // 125 MHz

  mt_fetch_unit #(.NUM_THREADS(NT), .RESET_PC(32'h0)) u_mt_fetch_unit (
    .clk(clk), .rst_n(rst_n), .thread_sel(thread_sel), .req_ready(req_ready),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_target(redir_target),
    .req_valid(req_valid), .req_addr(req_addr), .req_off(req_off),
    .req_tid(req_tid), .flush(flush), .flush_tid(flush_tid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read a thread's PC through the request port without a clock edge
  task automatic peek(input int tid, input string tag);
    thread_sel = tid[0]; req_ready = 1'b0; redir_valid = 1'b0;
    #1;
    check(tag, {req_addr, req_off}, model[tid]);
    check({tag, " tid"}, {31'd0, req_tid}, tid);
  endtask

  // one clock with given inputs; the model follows the requirements
  task automatic step(input int sel, input logic rdy, input logic rv,
                      input int rtid, input logic [31:0] tgt);
    thread_sel = sel[0]; req_ready = rdy; redir_valid = rv;
    redir_tid = rtid[0]; redir_target = tgt;
    @(posedge clk);
    if (rdy) model[sel] = model[sel] + 32'd4;  // R3
    if (rv)  model[rtid] = tgt;                // R5, R7 redirect last
    @(negedge clk);
    check("R8 flush", {31'd0, flush}, {31'd0, rv});
    if (rv) check("R8 flush_tid", {31'd0, flush_tid}, rtid);
    redir_valid = 1'b0; req_ready = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, req_valid}, 0);
    check("R1 flush in reset", {31'd0, flush}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < NT; t++) model[t] = 32'h0;
    peek(0, "R1 pc0");
    peek(1, "R1 pc1");
    check("R2 valid", {31'd0, req_valid}, 1);
  endtask

  task automatic t_sequential;
    for (int i = 0; i < 3; i++) step(0, 1'b1, 1'b0, 0, '0);
    peek(0, "R3 pc0 after 3 steps");
    check("R3 value", model[0], 32'd12);
    peek(1, "R3 pc1 untouched");
  endtask

  task automatic t_stall;
    for (int i = 0; i < 4; i++) step(1, 1'b0, 1'b0, 0, '0);
    peek(1, "R4 pc1 stalled");
    peek(0, "R4 pc0 stalled");
  endtask

  task automatic t_redirect;
    step(1, 1'b0, 1'b1, 1, 32'h1000_0003);
    peek(1, "R5 pc1 loaded");
    check("R2 offset bits", {30'd0, req_off}, 32'd3);
    peek(0, "R5 pc0 untouched");
    step(1, 1'b1, 1'b0, 0, '0);
    peek(1, "R3 offset kept");
  endtask

  task automatic t_cross;
    step(0, 1'b1, 1'b1, 1, 32'h0000_4000);
    peek(0, "R6 pc0 advanced");
    peek(1, "R6 pc1 redirected");
  endtask

  task automatic t_same;
    step(1, 1'b1, 1'b1, 1, 32'h0000_8001);
    peek(1, "R7 redirect wins");
    check("R7 value", model[1], 32'h0000_8001);
  endtask

  task automatic t_wrap;
    step(0, 1'b0, 1'b1, 0, 32'hFFFF_FFFE);
    step(0, 1'b1, 1'b0, 0, '0);
    peek(0, "R9 wrap");
    check("R9 value", model[0], 32'h0000_0002);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sequential();
    t_stall();
    t_redirect();
    t_cross();
    t_same();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule